// File: doc/BRIEF.md
# Multichannel DMA Control Register Bank

This block holds the software-visible control and status state of a descriptor-based, multichannel DMA layer. It connects to a simple device-control register bus. The bus carries a 10-bit register number, a 32-bit write data path, a registered 32-bit read data path, and separate read and write strobes. Beside the bus, the descriptor engine drives single-cycle event pulses into the bank. These pulses set end-of-buffer, descriptor-error and error-status bits. Software reads the bits back and clears them by writing ones.

The bank contains these registers:

- a configuration register with a soft-reset bit;
- an error status register;
- an interrupt enable register;
- per-direction channel-active, end-of-buffer and descriptor-error registers;
- one table pointer for each transmit channel;
- one table pointer and one 8-bit buffer size for each receive channel.

The transmit and receive channel counts are parameters, each from 1 to 32. They decide at decode time which numbers inside the three 32-entry channel windows exist. Bit i of every per-channel status register belongs to channel i.

Register numbers (hex):

| Number | Register | Write behaviour |
|---|---|---|
| 180 | config | masked load, soft reset on bit 31 |
| 181 | error status | write-one-to-clear |
| 182 | interrupt enable | plain read/write |
| 184 | transmit active set | OR into transmit active |
| 185 | transmit active clear | clear transmit active bits |
| 186 | transmit end-of-buffer | write-one-to-clear |
| 187 | transmit descriptor-error | write-one-to-clear |
| 190 | receive active set | OR into receive active |
| 191 | receive active clear | clear receive active bits |
| 192 | receive end-of-buffer | write-one-to-clear |
| 193 | receive descriptor-error | write-one-to-clear |
| 1A0 + i | transmit pointer, channel i | full 32-bit store |
| 1C0 + i | receive pointer, channel i | full 32-bit store |
| 1E0 + i | receive buffer size, channel i | bits 7:0 kept |

Top module: `dmacr_bank`

## Requirements
- R1: After reset, config reads 0x0007C000. Error status, interrupt enable and all active, end-of-buffer and descriptor-error registers read zero.
- R2: Read data appears on `rdata` in the cycle after the cycle where `rd_en` is high, and holds until the next read. A read returns the value from before any write in the same cycle.
- R3: A config write stores the written value ANDed with 0x00FFC087.
- R4: A config write with bit 31 set clears error status, interrupt enable and all active, end-of-buffer and descriptor-error registers. Event pulses in that same cycle are dropped. Config then takes the masked value.
- R5: Error status, end-of-buffer and descriptor-error registers clear each bit written as 1 and keep the others. An event setting the same bit in the same cycle wins.
- R6: Writing an active-set number ORs the data into that direction's active register. Writing the active-clear number clears the bits written as 1. Bits at or above the channel count stay zero. Both numbers read the active register.
- R7: Interrupt enable stores and returns all 32 bits written.
- R8: Number 0x1A0+i, for i below the transmit count, stores and returns a full 32-bit transmit pointer.
- R9: Number 0x1C0+i stores a full 32-bit receive pointer, and 0x1E0+i stores a receive buffer size, for i below the receive count. A size keeps only bits 7:0, and bits 31:8 read as zero.
- R10: Reads of unmapped numbers, or of window slots at or above the channel count, return zero. Writes to them change no state.
- R11: Channel pointers and buffer sizes are not affected by the soft reset of R4.
- R12: A high bit i on `tx_eob_set`, `rx_eob_set`, `tx_derr_set`, `rx_derr_set` or `err_set` sets bit i of the matching status register at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 10 | Register number of the access |
| wr_en | input | 1 | Write strobe, takes effect at this clock edge |
| rd_en | input | 1 | Read strobe, data follows one cycle later |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tx_eob_set | input | TX_CH | Transmit end-of-buffer event pulses |
| rx_eob_set | input | RX_CH | Receive end-of-buffer event pulses |
| tx_derr_set | input | TX_CH | Transmit descriptor-error event pulses |
| rx_derr_set | input | RX_CH | Receive descriptor-error event pulses |
| err_set | input | 32 | Error status event pulses |

## Verification
The assertions assume three things about the inputs:

- `rd_en` and `wr_en` are never high during reset.
- Event pulses are driven only from the clock edge where they are meant to count.
- The channel-table contents are never read before software has written them. Those slots have no reset value.

The stimulus keeps to these limits. It holds every strobe and event low during reset, and it changes inputs only on the falling clock edge. The post-reset sweep skips the in-range channel slots until a full write pass has loaded every one of them with a known pattern.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned NUM_W  = 10;
    localparam int unsigned SIZE_W = 8;
    localparam int unsigned MAX_CH = 32;
    localparam int unsigned SLOT_W = 5;

    localparam logic [NUM_W-1:0] RN_CFG        = 10'h180;
    localparam logic [NUM_W-1:0] RN_ERR        = 10'h181;
    localparam logic [NUM_W-1:0] RN_IEN        = 10'h182;
    localparam logic [NUM_W-1:0] RN_TXACT_SET  = 10'h184;
    localparam logic [NUM_W-1:0] RN_TXACT_CLR  = 10'h185;
    localparam logic [NUM_W-1:0] RN_TXEOB      = 10'h186;
    localparam logic [NUM_W-1:0] RN_TXDERR     = 10'h187;
    localparam logic [NUM_W-1:0] RN_RXACT_SET  = 10'h190;
    localparam logic [NUM_W-1:0] RN_RXACT_CLR  = 10'h191;
    localparam logic [NUM_W-1:0] RN_RXEOB      = 10'h192;
    localparam logic [NUM_W-1:0] RN_RXDERR     = 10'h193;
    localparam logic [NUM_W-1:0] WIN_TXPTR     = 10'h1A0;
    localparam logic [NUM_W-1:0] WIN_RXPTR     = 10'h1C0;
    localparam logic [NUM_W-1:0] WIN_RXSIZE    = 10'h1E0;

    localparam logic [DATA_W-1:0] CFG_RESET = 32'h0007_C000;
    localparam logic [DATA_W-1:0] CFG_WMASK = 32'h00FF_C087;
    localparam int unsigned       SOFT_RST_BIT = 31;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_ERR,
        SEL_IEN,
        SEL_TXACT_SET,
        SEL_TXACT_CLR,
        SEL_TXEOB,
        SEL_TXDERR,
        SEL_RXACT_SET,
        SEL_RXACT_CLR,
        SEL_RXEOB,
        SEL_RXDERR,
        SEL_TXPTR,
        SEL_RXPTR,
        SEL_RXSIZE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e           sel;
        logic [SLOT_W-1:0]  slot;
    } decode_t;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] err;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] txact;
        logic [DATA_W-1:0] rxact;
        logic [DATA_W-1:0] txeob;
        logic [DATA_W-1:0] rxeob;
        logic [DATA_W-1:0] txderr;
        logic [DATA_W-1:0] rxderr;
    } ctrl_state_t;

    function automatic logic [DATA_W-1:0] low_ones(input int unsigned n);
        logic [63:0] wide;
        wide = (64'd1 << n) - 64'd1;
        return wide[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dmacr_decode.sv
module dmacr_decode
    import dmacr_pkg::*;
#(
    parameter int unsigned TX_CH = 4,
    parameter int unsigned RX_CH = 2
) (
    input  logic [NUM_W-1:0] reg_num,
    output decode_t          dec
);

    localparam logic [SLOT_W:0] TX_LIM = (SLOT_W+1)'(TX_CH);
    localparam logic [SLOT_W:0] RX_LIM = (SLOT_W+1)'(RX_CH);
    localparam int unsigned     WSEL_W = NUM_W - SLOT_W;

    logic [WSEL_W-1:0] win_id;
    logic [SLOT_W:0]   offs;
    logic              tx_in_range;
    logic              rx_in_range;

    always_comb begin
        win_id      = reg_num[NUM_W-1:SLOT_W];
        offs        = {1'b0, reg_num[SLOT_W-1:0]};
        tx_in_range = offs < TX_LIM;
        rx_in_range = offs < RX_LIM;

        dec.sel  = SEL_NONE;
        dec.slot = reg_num[SLOT_W-1:0];

        unique case (reg_num)
            RN_CFG:       dec.sel = SEL_CFG;
            RN_ERR:       dec.sel = SEL_ERR;
            RN_IEN:       dec.sel = SEL_IEN;
            RN_TXACT_SET: dec.sel = SEL_TXACT_SET;
            RN_TXACT_CLR: dec.sel = SEL_TXACT_CLR;
            RN_TXEOB:     dec.sel = SEL_TXEOB;
            RN_TXDERR:    dec.sel = SEL_TXDERR;
            RN_RXACT_SET: dec.sel = SEL_RXACT_SET;
            RN_RXACT_CLR: dec.sel = SEL_RXACT_CLR;
            RN_RXEOB:     dec.sel = SEL_RXEOB;
            RN_RXDERR:    dec.sel = SEL_RXDERR;
            default: begin
                if (win_id == WIN_TXPTR[NUM_W-1:SLOT_W] && tx_in_range) begin
                    dec.sel = SEL_TXPTR;
                end else if (win_id == WIN_RXPTR[NUM_W-1:SLOT_W] && rx_in_range) begin
                    dec.sel = SEL_RXPTR;
                end else if (win_id == WIN_RXSIZE[NUM_W-1:SLOT_W] && rx_in_range) begin
                    dec.sel = SEL_RXSIZE;
                end
            end
        endcase
    end

endmodule

// File: rtl/dmacr_ctrl_regs.sv
module dmacr_ctrl_regs
    import dmacr_pkg::*;
#(
    parameter int unsigned TX_CH = 4,
    parameter int unsigned RX_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TX_CH-1:0]  tx_eob_set,
    input  logic [RX_CH-1:0]  rx_eob_set,
    input  logic [TX_CH-1:0]  tx_derr_set,
    input  logic [RX_CH-1:0]  rx_derr_set,
    input  logic [DATA_W-1:0] err_set,
    output ctrl_state_t       state
);

    localparam logic [DATA_W-1:0] TX_MASK = low_ones(TX_CH);
    localparam logic [DATA_W-1:0] RX_MASK = low_ones(RX_CH);

    ctrl_state_t state_d;
    ctrl_state_t state_q;

    logic              soft_rst;
    logic [DATA_W-1:0] tx_eob_ext;
    logic [DATA_W-1:0] rx_eob_ext;
    logic [DATA_W-1:0] tx_derr_ext;
    logic [DATA_W-1:0] rx_derr_ext;
    logic [DATA_W-1:0] clr_err;
    logic [DATA_W-1:0] clr_txeob;
    logic [DATA_W-1:0] clr_rxeob;
    logic [DATA_W-1:0] clr_txderr;
    logic [DATA_W-1:0] clr_rxderr;
    logic [DATA_W-1:0] clr_txact;
    logic [DATA_W-1:0] clr_rxact;
    logic [DATA_W-1:0] set_txact;
    logic [DATA_W-1:0] set_rxact;

    // Widen per-channel event vectors to register width.
    always_comb begin
        tx_eob_ext  = '0;
        rx_eob_ext  = '0;
        tx_derr_ext = '0;
        rx_derr_ext = '0;
        tx_eob_ext[TX_CH-1:0]  = tx_eob_set;
        rx_eob_ext[RX_CH-1:0]  = rx_eob_set;
        tx_derr_ext[TX_CH-1:0] = tx_derr_set;
        rx_derr_ext[RX_CH-1:0] = rx_derr_set;
    end

    // Per-register clear and set masks from the bus write.
    always_comb begin
        clr_err    = (wr_en && sel == SEL_ERR)       ? wdata : '0;
        clr_txeob  = (wr_en && sel == SEL_TXEOB)     ? wdata : '0;
        clr_rxeob  = (wr_en && sel == SEL_RXEOB)     ? wdata : '0;
        clr_txderr = (wr_en && sel == SEL_TXDERR)    ? wdata : '0;
        clr_rxderr = (wr_en && sel == SEL_RXDERR)    ? wdata : '0;
        clr_txact  = (wr_en && sel == SEL_TXACT_CLR) ? wdata : '0;
        clr_rxact  = (wr_en && sel == SEL_RXACT_CLR) ? wdata : '0;
        set_txact  = (wr_en && sel == SEL_TXACT_SET) ? (wdata & TX_MASK) : '0;
        set_rxact  = (wr_en && sel == SEL_RXACT_SET) ? (wdata & RX_MASK) : '0;
        soft_rst   = wr_en && sel == SEL_CFG && wdata[SOFT_RST_BIT];
    end

    always_comb begin
        state_d = state_q;

        // Write-one-to-clear, with a same-cycle event taking priority.
        state_d.err    = (state_q.err    & ~clr_err)    | err_set;
        state_d.txeob  = (state_q.txeob  & ~clr_txeob)  | tx_eob_ext;
        state_d.rxeob  = (state_q.rxeob  & ~clr_rxeob)  | rx_eob_ext;
        state_d.txderr = (state_q.txderr & ~clr_txderr) | tx_derr_ext;
        state_d.rxderr = (state_q.rxderr & ~clr_rxderr) | rx_derr_ext;

        state_d.txact  = (state_q.txact & ~clr_txact) | set_txact;
        state_d.rxact  = (state_q.rxact & ~clr_rxact) | set_rxact;

        if (wr_en && sel == SEL_IEN) begin
            state_d.ien = wdata;
        end

        if (soft_rst) begin
            state_d.err    = '0;
            state_d.ien    = '0;
            state_d.txact  = '0;
            state_d.rxact  = '0;
            state_d.txeob  = '0;
            state_d.rxeob  = '0;
            state_d.txderr = '0;
            state_d.rxderr = '0;
        end

        if (wr_en && sel == SEL_CFG) begin
            state_d.cfg = wdata & CFG_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.cfg    <= CFG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG) |=> (state_q.cfg == ($past(wdata) & CFG_WMASK))); // R3

    AST_SOFT_CLEARS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CFG && wdata[SOFT_RST_BIT]) |=> (state_q.ien == '0 && state_q.txeob == '0)); // R4

    AST_DERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_TXDERR && tx_derr_set == '0)
            |=> ((state_q.txderr & $past(wdata)) == '0)); // R5

    AST_ACT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RXACT_SET) |=> ((state_q.rxact & ~RX_MASK) == '0)); // R6

    AST_EOB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eob_set != '0 && !soft_rst)
            |=> ((state_q.txeob[TX_CH-1:0] & $past(tx_eob_set)) == $past(tx_eob_set))); // R12

endmodule

// File: rtl/dmacr_chan_table.sv
module dmacr_chan_table
    import dmacr_pkg::*;
#(
    parameter int unsigned N_SLOT = 4,
    parameter int unsigned WIDTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] slot_d [N_SLOT];
    logic [WIDTH-1:0] slot_q [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] IDX = SLOT_W'(g);

        always_comb begin
            slot_d[g] = slot_q[g];
            if (wr_en && slot == IDX) begin
                slot_d[g] = wdata;
            end
        end

        // Table contents carry no reset value.
        always_ff @(posedge clk) begin
            slot_q[g] <= slot_d[g];
        end

        AST_SLOT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && slot == IDX) |=> (slot_q[g] == $past(wdata))); // R8
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (slot == SLOT_W'(i)) begin
                rdata = slot_q[i];
            end
        end
    end

endmodule

// File: rtl/dmacr_bank.sv
module dmacr_bank
    import dmacr_pkg::*;
#(
    parameter int unsigned TX_CH = 4,
    parameter int unsigned RX_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        reg_num,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [TX_CH-1:0]  tx_eob_set,
    input  logic [RX_CH-1:0]  rx_eob_set,
    input  logic [TX_CH-1:0]  tx_derr_set,
    input  logic [RX_CH-1:0]  rx_derr_set,
    input  logic [31:0]       err_set
);

    initial begin
        if (TX_CH < 1 || TX_CH > MAX_CH || RX_CH < 1 || RX_CH > MAX_CH) begin
            $error("channel counts must lie in 1..32");
        end
    end

    decode_t           dec;
    ctrl_state_t       ctrl;
    logic [DATA_W-1:0] txptr_rd;
    logic [DATA_W-1:0] rxptr_rd;
    logic [SIZE_W-1:0] rxsize_rd;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;

    dmacr_decode #(
        .TX_CH (TX_CH),
        .RX_CH (RX_CH)
    ) i_decode (
        .reg_num (reg_num),
        .dec     (dec)
    );

    dmacr_ctrl_regs #(
        .TX_CH (TX_CH),
        .RX_CH (RX_CH)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .sel         (dec.sel),
        .wdata       (wdata),
        .tx_eob_set  (tx_eob_set),
        .rx_eob_set  (rx_eob_set),
        .tx_derr_set (tx_derr_set),
        .rx_derr_set (rx_derr_set),
        .err_set     (err_set),
        .state       (ctrl)
    );

    dmacr_chan_table #(
        .N_SLOT (TX_CH),
        .WIDTH  (DATA_W)
    ) i_txptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en && dec.sel == SEL_TXPTR),
        .slot  (dec.slot),
        .wdata (wdata),
        .rdata (txptr_rd)
    );

    dmacr_chan_table #(
        .N_SLOT (RX_CH),
        .WIDTH  (DATA_W)
    ) i_rxptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en && dec.sel == SEL_RXPTR),
        .slot  (dec.slot),
        .wdata (wdata),
        .rdata (rxptr_rd)
    );

    dmacr_chan_table #(
        .N_SLOT (RX_CH),
        .WIDTH  (SIZE_W)
    ) i_rxsize (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en && dec.sel == SEL_RXSIZE),
        .slot  (dec.slot),
        .wdata (wdata[SIZE_W-1:0]),
        .rdata (rxsize_rd)
    );

    always_comb begin
        rd_value = '0;
        unique case (dec.sel)
            SEL_CFG:       rd_value = ctrl.cfg;
            SEL_ERR:       rd_value = ctrl.err;
            SEL_IEN:       rd_value = ctrl.ien;
            SEL_TXACT_SET,
            SEL_TXACT_CLR: rd_value = ctrl.txact;
            SEL_TXEOB:     rd_value = ctrl.txeob;
            SEL_TXDERR:    rd_value = ctrl.txderr;
            SEL_RXACT_SET,
            SEL_RXACT_CLR: rd_value = ctrl.rxact;
            SEL_RXEOB:     rd_value = ctrl.rxeob;
            SEL_RXDERR:    rd_value = ctrl.rxderr;
            SEL_TXPTR:     rd_value = txptr_rd;
            SEL_RXPTR:     rd_value = rxptr_rd;
            SEL_RXSIZE:    rd_value = {{(DATA_W-SIZE_W){1'b0}}, rxsize_rd};
            default:       rd_value = '0;
        endcase
    end

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            rdata_d = rd_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.sel == SEL_NONE) |=> (rdata == '0)); // R10

    AST_SIZE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.sel == SEL_RXSIZE) |=> (rdata[DATA_W-1:SIZE_W] == '0)); // R9

endmodule

// File: tb/test_dmacr_bank.sv
module test_dmacr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int TXN = 4;
    localparam int RXN = 2;
    localparam logic [31:0] TXM = 32'h0000_000F;
    localparam logic [31:0] RXM = 32'h0000_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_num = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [TXN-1:0] tx_eob_set = '0;
    logic [RXN-1:0] rx_eob_set = '0;
    logic [TXN-1:0] tx_derr_set = '0;
    logic [RXN-1:0] rx_derr_set = '0;
    logic [31:0]    err_set = '0;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_cfg, m_err, m_ien, m_txact, m_rxact;
    logic [31:0] m_txeob, m_rxeob, m_txde, m_rxde;
    logic [31:0] m_txp [TXN];
    logic [31:0] m_rxp [RXN];
    logic [31:0] m_rxs [RXN];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmacr_bank #(.TX_CH(TXN), .RX_CH(RXN)) i_dmacr_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_num     (reg_num),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .tx_eob_set  (tx_eob_set),
        .rx_eob_set  (rx_eob_set),
        .tx_derr_set (tx_derr_set),
        .rx_derr_set (rx_derr_set),
        .err_set     (err_set)
    );

    function automatic bit is_slot(input int n);
        return (n >= 'h1A0 && n < 'h1A0 + TXN) ||
               (n >= 'h1C0 && n < 'h1C0 + RXN) ||
               (n >= 'h1E0 && n < 'h1E0 + RXN);
    endfunction

    function automatic bit is_fixed(input int n);
        return n == 'h180 || n == 'h181 || n == 'h182 ||
               (n >= 'h184 && n <= 'h187) || (n >= 'h190 && n <= 'h193);
    endfunction

    function automatic logic [31:0] pat(input int n);
        return (32'(n) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] model_read(input int n);
        if (n == 'h180) return m_cfg;
        if (n == 'h181) return m_err;
        if (n == 'h182) return m_ien;
        if (n == 'h184 || n == 'h185) return m_txact;
        if (n == 'h186) return m_txeob;
        if (n == 'h187) return m_txde;
        if (n == 'h190 || n == 'h191) return m_rxact;
        if (n == 'h192) return m_rxeob;
        if (n == 'h193) return m_rxde;
        if (n >= 'h1A0 && n < 'h1A0 + TXN) return m_txp[n - 'h1A0];
        if (n >= 'h1C0 && n < 'h1C0 + RXN) return m_rxp[n - 'h1C0];
        if (n >= 'h1E0 && n < 'h1E0 + RXN) return m_rxs[n - 'h1E0];
        return 32'h0;
    endfunction

    task automatic model_clear_status();
        m_err = '0; m_ien = '0; m_txact = '0; m_rxact = '0;
        m_txeob = '0; m_rxeob = '0; m_txde = '0; m_rxde = '0;
    endtask

    task automatic model_write(input int n, input logic [31:0] v);
        if (n == 'h180) begin
            if (v[31]) model_clear_status();
            m_cfg = v & 32'h00FF_C087;
        end else if (n == 'h181) m_err &= ~v;
        else if (n == 'h182) m_ien = v;
        else if (n == 'h184) m_txact |= v & TXM;
        else if (n == 'h185) m_txact &= ~v;
        else if (n == 'h186) m_txeob &= ~v;
        else if (n == 'h187) m_txde &= ~v;
        else if (n == 'h190) m_rxact |= v & RXM;
        else if (n == 'h191) m_rxact &= ~v;
        else if (n == 'h192) m_rxeob &= ~v;
        else if (n == 'h193) m_rxde &= ~v;
        else if (n >= 'h1A0 && n < 'h1A0 + TXN) m_txp[n - 'h1A0] = v;
        else if (n >= 'h1C0 && n < 'h1C0 + RXN) m_rxp[n - 'h1C0] = v;
        else if (n >= 'h1E0 && n < 'h1E0 + RXN) m_rxs[n - 'h1E0] = v & 32'hFF;
    endtask

    // Bus write: starts and ends at a falling edge.
    task automatic bus_write(input int n, input logic [31:0] v);
        reg_num = n[9:0];
        wdata   = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic check_val(input string req, input int n,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s reg 0x%03h actual 0x%08h expected 0x%08h", req, n, act, exp);
        end
    endtask

    task automatic bus_read_check(input int n, input string req);
        reg_num = n[9:0];
        rd_en   = 1'b1;
        @(negedge clk);
        rd_en   = 1'b0;
        check_val(req, n, rdata, model_read(n));
    endtask

    task automatic sweep_all(input string req, input bit skip_slots);
        for (int n = 0; n < 1024; n++) begin
            if (!(skip_slots && is_slot(n))) bus_read_check(n, req);
        end
    endtask

    task automatic pulse_events(input logic [TXN-1:0] te, input logic [RXN-1:0] re,
                                input logic [TXN-1:0] td, input logic [RXN-1:0] rd,
                                input logic [31:0] er);
        tx_eob_set = te; rx_eob_set = re; tx_derr_set = td; rx_derr_set = rd; err_set = er;
        @(negedge clk);
        tx_eob_set = '0; rx_eob_set = '0; tx_derr_set = '0; rx_derr_set = '0; err_set = '0;
        m_txeob |= 32'(te); m_rxeob |= 32'(re);
        m_txde  |= 32'(td); m_rxde  |= 32'(rd);
        m_err   |= er;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        m_cfg = 32'h0007_C000;
        model_clear_status();
        for (int i = 0; i < TXN; i++) m_txp[i] = '0;
        for (int i = 0; i < RXN; i++) begin m_rxp[i] = '0; m_rxs[i] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values; R2/R10 unmapped reads return zero
        sweep_all("R1", 1'b1);

        // R8 transmit pointers, R9 receive pointers and sizes
        for (int n = 0; n < 1024; n++) begin
            if (is_slot(n)) begin
                bus_write(n, pat(n));
                model_write(n, pat(n));
            end
        end
        for (int n = 'h1A0; n < 'h1A0 + TXN; n++) bus_read_check(n, "R8");
        for (int n = 'h1C0; n < 'h1C0 + RXN; n++) bus_read_check(n, "R9");
        for (int n = 'h1E0; n < 'h1E0 + RXN; n++) bus_read_check(n, "R9");

        // R10 writes to unmapped numbers and out-of-range slots change nothing
        for (int n = 0; n < 1024; n++) begin
            if (!is_slot(n) && !is_fixed(n)) bus_write(n, 32'hFFFF_FFFF);
        end
        sweep_all("R10", 1'b0);

        // R2 read returns pre-write value when write shares the cycle
        reg_num = 10'h182; wdata = 32'hDEAD_BEEF; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_val("R2", 'h182, rdata, 32'h0);
        m_ien = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        check_val("R2", 'h182, rdata, 32'h0);

        // R3 masked config load
        bus_write('h180, 32'h7FFF_FFFF); model_write('h180, 32'h7FFF_FFFF);
        bus_read_check('h180, "R3");
        bus_write('h180, 32'h0012_4001); model_write('h180, 32'h0012_4001);
        bus_read_check('h180, "R3");

        // R7 interrupt enable
        bus_write('h182, 32'h1234_5678); model_write('h182, 32'h1234_5678);
        bus_read_check('h182, "R7");

        // R12 event capture
        pulse_events(4'b1010, 2'b01, 4'b0110, 2'b11, 32'h8000_0001);
        for (int n = 'h181; n <= 'h193; n++) if (is_fixed(n)) bus_read_check(n, "R12");

        // R5 write-one-to-clear
        bus_write('h186, 32'h2);          model_write('h186, 32'h2);
        bus_write('h187, 32'hFFFF_FFFF);  model_write('h187, 32'hFFFF_FFFF);
        bus_write('h181, 32'h1);          model_write('h181, 32'h1);
        bus_write('h193, 32'h2);          model_write('h193, 32'h2);
        bus_read_check('h186, "R5");
        bus_read_check('h187, "R5");
        bus_read_check('h181, "R5");
        bus_read_check('h193, "R5");
        // R5 event wins over a same-cycle clear
        rx_eob_set = 2'b01;
        bus_write('h192, 32'h1);
        rx_eob_set = '0;
        model_write('h192, 32'h1);
        m_rxeob |= 32'h1;
        bus_read_check('h192, "R5");

        // R6 active set and clear, bounded by channel count
        bus_write('h184, 32'hFFFF_FFFF); model_write('h184, 32'hFFFF_FFFF);
        bus_read_check('h184, "R6");
        bus_write('h185, 32'h5);         model_write('h185, 32'h5);
        bus_read_check('h185, "R6");
        bus_read_check('h184, "R6");
        bus_write('h190, 32'hFFFF_FFFE); model_write('h190, 32'hFFFF_FFFE);
        bus_read_check('h191, "R6");
        bus_write('h191, 32'h2);         model_write('h191, 32'h2);
        bus_read_check('h190, "R6");

        // R4 soft reset, with same-cycle events dropped; R11 tables retained
        bus_write('h190, 32'h3);         model_write('h190, 32'h3);
        tx_eob_set = 4'hF; err_set = 32'h10;
        bus_write('h180, 32'h8000_0081);
        tx_eob_set = '0; err_set = '0;
        model_write('h180, 32'h8000_0081);
        for (int n = 'h180; n <= 'h193; n++) if (is_fixed(n)) bus_read_check(n, "R4");
        for (int n = 0; n < 1024; n++) if (is_slot(n)) bus_read_check(n, "R11");

        finish_run();
    end

endmodule